// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides, for each received Ethernet frame, whether the frame is kept or dropped. The receive path streams the frame's bytes into it, marking the first byte with a start-of-frame strobe. The block collects the six destination address bytes and classifies the address as unicast, multicast or broadcast. It compares the address against a table of programmable address entries and combines the result with per-class accept bits. One clock edge after the sixth address byte is sampled, it presents a one-cycle decision.

Software sets the filter up through a write-only word register interface. A command word holds the class accept bits and the compare controls. An enable word switches table entries on one by one. Each entry is loaded through two 32-bit words. The whole configuration is copied into a shadow set at every start-of-frame, so reprogramming during a frame never changes that frame's decision.

The typical set-ups are a normal mode, in which only compare-enable and accept-broadcast are set, and a promiscuous mode, in which all three class bits and compare-enable are set.

Top module: `eth_addr_filter`

## Requirements
- R1: After reset, `dec_valid` is low and every register holds zero, so any frame completed without configuration is rejected.
- R2: `dec_valid` is high for exactly one cycle, the cycle after the edge that samples the sixth destination byte. Bytes after the sixth produce no further decision until the next start-of-frame.
- R3: The command word is at offset 0x00. Its bit 0 accepts every unicast frame, bit 1 every multicast frame and bit 2 every broadcast frame. Bit 3 inverts the table compare result, and bit 4 enables the table compare.
- R4: Entry n has its high word at offset 0x08+8n, carrying address bytes 0..3 with byte 0 in bits 31:24. Its low word is at offset 0x0C+8n, carrying byte 4 in bits 31:24 and byte 5 in bits 23:16; bits 15:0 of the low word are ignored. Byte 0 is the first byte received.
- R5: The enable word is at offset 0x04, and bit n enables entry n. A disabled entry never produces a hit.
- R6: An address of all ones is broadcast. Any other address whose first byte has bit 0 set is multicast. All other addresses are unicast.
- R7: The decision is accept = (class accept bit of the address class) OR (compare-enable AND (table hit XOR invert)).
- R8: A start-of-frame strobe (`rx_sof` together with `rx_byte_vld`) discards any partly collected address and takes the strobed byte as byte 0.
- R9: A register write made after a frame's start-of-frame affects only frames that start later.
- R10: Writes to offsets outside the map (unaligned offsets, or 0x88 and above) change nothing.
- R11: Cycles with `rx_byte_vld` low are skipped. Address bytes may arrive with gaps between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (8) | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| rx_sof | input | 1 | Marks the current byte as the first of a frame |
| rx_byte_vld | input | 1 | `rx_byte` carries a frame byte this cycle |
| rx_byte | input | 8 | Received frame byte |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Decision; meaningful only while `dec_valid` is high |

## Verification
The decision is due exactly one edge after the sixth address byte. The bench drives each byte just after a falling edge and samples both outputs at the first falling edge after the last byte. It samples again one edge later to confirm that the strobe has dropped. Register writes take one edge, and the bench starts every frame after its writes have completed, except in the test that writes deliberately in the middle of a frame. The sweep covers all 32 command values against six address kinds: table hit, table miss, disabled entry, multicast hit and miss, and broadcast. The expected decision for each is computed from the accept equation.

// File: rtl/filt_pkg.sv
package filt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DONE = 2'd2
    } fsm_t;

    localparam int CMD_W      = 5;
    localparam int CMD_UNI    = 0;
    localparam int CMD_MULTI  = 1;
    localparam int CMD_BCAST  = 2;
    localparam int CMD_INVERT = 3;
    localparam int CMD_CMP_EN = 4;

    localparam int MAC_W      = 48;
    localparam int HOLD_BYTES = 5;
endpackage

// File: rtl/filt_regs.sv
module filt_regs
    import filt_pkg::*;
#(
    parameter int N      = 16,
    parameter int ADDR_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [31:0]             wdata,
    input  logic                    snap_load,
    output logic [CMD_W-1:0]        snap_cmd,
    output logic [N-1:0]            snap_en,
    output logic [N-1:0][MAC_W-1:0] snap_tab
);
    localparam logic [ADDR_W-1:0] OFF_CMD = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFF_EN  = ADDR_W'(4);

    logic [CMD_W-1:0]        live_cmd;
    logic [N-1:0]            live_en;
    logic [N-1:0][MAC_W-1:0] live_tab;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_cmd <= '0;
            live_en  <= '0;
        end else if (wr_en) begin
            if (addr == OFF_CMD) live_cmd <= wdata[CMD_W-1:0];
            if (addr == OFF_EN)  live_en  <= wdata[N-1:0];
        end
    end

    for (genvar n = 0; n < N; n++) begin : g_entry
        localparam logic [ADDR_W-1:0] OFF_HI = ADDR_W'(8 + 8 * n);
        localparam logic [ADDR_W-1:0] OFF_LO = ADDR_W'(12 + 8 * n);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                live_tab[n] <= '0;
            end else if (wr_en) begin
                if (addr == OFF_HI) live_tab[n][47:16] <= wdata;
                if (addr == OFF_LO) live_tab[n][15:0]  <= wdata[31:16];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_cmd <= '0;
            snap_en  <= '0;
            snap_tab <= '0;
        end else if (snap_load) begin
            snap_cmd <= live_cmd;
            snap_en  <= live_en;
            snap_tab <= live_tab;
        end
    end
endmodule

// File: rtl/filt_cam.sv
module filt_cam
    import filt_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N-1:0][MAC_W-1:0] tab,
    input  logic [N-1:0]            en,
    input  logic [MAC_W-1:0]        dest,
    output logic                    hit
);
    logic [N-1:0] match;

    for (genvar n = 0; n < N; n++) begin : g_cmp
        assign match[n] = en[n] && (tab[n] == dest);
    end

    assign hit = |match;
endmodule

// File: rtl/filt_fsm.sv
module filt_fsm
    import filt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_sof,
    input  logic                 rx_byte_vld,
    input  logic [7:0]           rx_byte,
    output logic                 snap_load,
    output logic                 last_byte,
    output logic [MAC_W-9:0]     head,
    output fsm_t                 state
);
    localparam logic [2:0] LAST_IDX = 3'(HOLD_BYTES);

    fsm_t       nxt;
    logic [2:0] cnt;
    logic [HOLD_BYTES-1:0][7:0] hold;
    logic       sof_now;

    assign sof_now = rx_sof && rx_byte_vld;

    always_comb begin
        nxt = state;
        if (sof_now) begin
            nxt = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE: nxt = ST_IDLE;
                ST_ADDR: if (rx_byte_vld && cnt == LAST_IDX) nxt = ST_DONE;
                ST_DONE: nxt = ST_DONE;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            hold <= '0;
        end else if (sof_now) begin
            hold    <= '0;
            hold[0] <= rx_byte;
            cnt     <= 3'd1;
        end else if (state == ST_ADDR && rx_byte_vld && cnt < LAST_IDX) begin
            hold[cnt] <= rx_byte;
            cnt       <= cnt + 3'd1;
        end
    end

    assign snap_load = sof_now;
    assign last_byte = !sof_now && state == ST_ADDR && rx_byte_vld && cnt == LAST_IDX;
    assign head      = {hold[0], hold[1], hold[2], hold[3], hold[4]};
endmodule

// File: rtl/eth_addr_filter.sv
module eth_addr_filter
    import filt_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int ADDR_W      = $clog2(8 + 8 * NUM_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              rx_sof,
    input  logic              rx_byte_vld,
    input  logic [7:0]        rx_byte,
    output logic              dec_valid,
    output logic              dec_accept
);
    logic [CMD_W-1:0]                  snap_cmd;
    logic [NUM_ENTRIES-1:0]            snap_en;
    logic [NUM_ENTRIES-1:0][MAC_W-1:0] snap_tab;
    logic                              snap_load;
    logic                              last_byte;
    logic [MAC_W-9:0]                  head;
    fsm_t                              state;
    logic [MAC_W-1:0]                  dest;
    logic                              hit;
    logic                              is_bcast;
    logic                              is_multi;
    logic                              class_ok;
    logic                              accept_now;

    filt_regs #(.N(NUM_ENTRIES), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
        .wdata(reg_wdata), .snap_load(snap_load), .snap_cmd(snap_cmd),
        .snap_en(snap_en), .snap_tab(snap_tab)
    );

    filt_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .rx_sof(rx_sof), .rx_byte_vld(rx_byte_vld),
        .rx_byte(rx_byte), .snap_load(snap_load), .last_byte(last_byte),
        .head(head), .state(state)
    );

    assign dest = {head, rx_byte};

    filt_cam #(.N(NUM_ENTRIES)) u_cam (
        .tab(snap_tab), .en(snap_en), .dest(dest), .hit(hit)
    );

    always_comb begin
        is_bcast = (dest == {MAC_W{1'b1}});
        is_multi = !is_bcast && dest[MAC_W-8];
        if (is_bcast)      class_ok = snap_cmd[CMD_BCAST];
        else if (is_multi) class_ok = snap_cmd[CMD_MULTI];
        else               class_ok = snap_cmd[CMD_UNI];
        accept_now = class_ok ||
                     (snap_cmd[CMD_CMP_EN] && (hit ^ snap_cmd[CMD_INVERT]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
        end else begin
            dec_valid  <= last_byte;
            dec_accept <= last_byte && accept_now;
        end
    end
endmodule

// File: rtl/filt_chk.sv
module filt_chk #(
    parameter int N = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         rx_sof,
    input logic         rx_byte_vld,
    input logic         dec_valid,
    input logic         dec_accept,
    input logic [4:0]   snap_cmd,
    input logic [N-1:0] snap_en
);
    // R2: decision strobe lasts a single cycle
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);

    // R2: accept is only raised together with the strobe
    a_r2_accept_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> !dec_accept);

    // R8: a start-of-frame byte never yields a decision on the next cycle
    a_r8_sof_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_sof && rx_byte_vld) |=> !dec_valid);

    // R11: a decision is always preceded by a valid byte
    a_r11_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(rx_byte_vld));

    // R7: with every command bit clear, nothing is accepted
    a_r7_all_off_rejects: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && $past(snap_cmd) == 5'b0) |-> !dec_accept);

    // R5: compare-only mode with no enabled entries rejects
    a_r5_no_entries_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && $past(snap_cmd) == 5'b10000 && $past(snap_en) == '0)
            |-> !dec_accept);
endmodule

bind eth_addr_filter filt_chk #(.N(NUM_ENTRIES)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_sof(rx_sof), .rx_byte_vld(rx_byte_vld),
    .dec_valid(dec_valid), .dec_accept(dec_accept),
    .snap_cmd(snap_cmd), .snap_en(snap_en)
);

// File: tb/tb_eth_addr_filter.sv
module tb_eth_addr_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        rx_sof = 1'b0;
    logic        rx_byte_vld = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        dec_valid;
    logic        dec_accept;

    int vectors = 0;
    int fails = 0;

    logic [47:0] m_tab [16];
    logic [15:0] m_en;
    logic [4:0]  m_cmd;

    localparam logic [47:0] UA = 48'h02_11_22_33_44_55;
    localparam logic [47:0] UM = 48'h02_11_22_33_44_56;
    localparam logic [47:0] MA = 48'h01_00_5E_00_00_07;
    localparam logic [47:0] MM = 48'h33_33_00_00_00_01;
    localparam logic [47:0] BC = 48'hFF_FF_FF_FF_FF_FF;
    localparam logic [47:0] UD = 48'h0A_0B_0C_0D_0E_0F;

    eth_addr_filter dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .rx_sof(rx_sof), .rx_byte_vld(rx_byte_vld),
        .rx_byte(rx_byte), .dec_valid(dec_valid), .dec_accept(dec_accept)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    function automatic logic model(input logic [47:0] a, input logic [4:0] c,
                                   input logic [15:0] e);
        logic bc, mc, cls, hit;
        bc = (a == BC);
        mc = !bc && a[40];
        cls = bc ? c[2] : (mc ? c[1] : c[0]);
        hit = 1'b0;
        for (int i = 0; i < 16; i++) if (e[i] && m_tab[i] == a) hit = 1'b1;
        return cls | (c[4] & (hit ^ c[3]));
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic set_cmd(input logic [4:0] c);
        wr(8'h00, {27'd0, c}); m_cmd = c;
    endtask

    task automatic set_en(input logic [15:0] e);
        wr(8'h04, {16'd0, e}); m_en = e;
    endtask

    task automatic load_entry(input int n, input logic [47:0] a, input logic [15:0] junk);
        wr(8'(8 + 8 * n), a[47:16]);
        wr(8'(12 + 8 * n), {a[15:0], junk});
        m_tab[n] = a;
    endtask

    // sends six address bytes; optional gap cycles, optional mid-frame write
    task automatic send(input logic [47:0] a, input int gap, input int wr_after,
                        input logic [7:0] wa, input logic [31:0] wd,
                        output logic v, output logic acc);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            rx_sof = (i == 0); rx_byte_vld = 1'b1; rx_byte = a[47 - 8 * i -: 8];
            if (i == wr_after) begin
                @(negedge clk);
                rx_sof = 1'b0; rx_byte_vld = 1'b0;
                reg_wr_en = 1'b1; reg_addr = wa; reg_wdata = wd;
                @(negedge clk);
                reg_wr_en = 1'b0;
            end
            for (int g = 0; g < gap && i < 5; g++) begin
                @(negedge clk);
                rx_sof = 1'b0; rx_byte_vld = 1'b0;
            end
        end
        @(negedge clk);
        rx_sof = 1'b0; rx_byte_vld = 1'b0;
        v = dec_valid; acc = dec_accept;
    endtask

    task automatic frame(input string req, input logic [47:0] a, input int gap);
        logic v, acc, exp;
        exp = model(a, m_cmd, m_en);
        send(a, gap, -1, 8'h0, 32'h0, v, acc);
        chk({req, " R2 valid"}, v, 1'b1);
        chk(req, acc, exp);
        @(negedge clk);
        chk({req, " R2 pulse end"}, dec_valid, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic v, acc;
        logic [47:0] addrs [6];
        addrs = '{UA, UM, MA, MM, BC, UD};
        for (int i = 0; i < 16; i++) m_tab[i] = '0;
        m_en = '0; m_cmd = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 valid after reset", dec_valid, 1'b0);
        frame("R1 unconfigured unicast", UA, 0);
        frame("R1 unconfigured broadcast", BC, 0);

        // R4: layout, low 16 bits of low word ignored
        load_entry(3, UA, 16'hBEEF);
        load_entry(9, MA, 16'h1234);
        load_entry(12, UD, 16'h0000);
        set_en(16'h0208);   // R5: entries 3 and 9 on, 12 off

        // R3 R6 R7 R5 R4: sweep every command over six address kinds
        for (int c = 0; c < 32; c++) begin
            set_cmd(5'(c));
            for (int k = 0; k < 6; k++) frame("R7 R3 R6 sweep", addrs[k], k % 2);
        end

        // R5: enabling entry 12 makes UD hit
        set_cmd(5'b10000);
        frame("R5 disabled entry", UD, 0);
        set_en(16'h1208);
        frame("R5 enabled entry", UD, 0);

        // R11: wide gaps between bytes
        frame("R11 gapped hit", UA, 3);

        // R8: partial frame then fresh start
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            rx_sof = (i == 0); rx_byte_vld = 1'b1; rx_byte = MM[47 - 8 * i -: 8];
        end
        @(negedge clk);
        rx_sof = 1'b0; rx_byte_vld = 1'b0;
        chk("R8 no decision on partial", dec_valid, 1'b0);
        frame("R8 restart hit", UA, 0);

        // R2: bytes beyond the sixth yield nothing
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            rx_byte_vld = 1'b1; rx_byte = 8'hFF;
            @(negedge clk);
            rx_byte_vld = 1'b0;
            chk("R2 no extra decision", dec_valid, 1'b0);
        end

        // R9: write during a frame applies to the next one
        set_cmd(5'b00001);
        send(UM, 0, 2, 8'h00, 32'h0, v, acc);
        chk("R9 old cmd used valid", v, 1'b1);
        chk("R9 old cmd used", acc, 1'b1);
        m_cmd = 5'b0;
        @(negedge clk);
        frame("R9 new cmd next frame", UM, 0);

        // R10: unmapped offsets ignored
        set_cmd(5'b10000);
        wr(8'h02, 32'h0000_001F);
        wr(8'h88, 32'h0211_2233);
        wr(8'h8C, 32'h4456_0000);
        wr(8'h06, 32'h0000_0000);
        frame("R10 unmapped cmd write", UM, 0);
        frame("R10 unmapped en write", UA, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule